// File: doc/BRIEF.md
# Dual-Bank Synchronous Graphics DRAM Controller

This block lets a simple host port reach a 32-bit synchronous graphics DRAM that holds two internal banks, each 2048 rows deep with 256 columns of 32-bit words. The host presents one word-sized request at a time through a valid/ready handshake. A request carries a read or write flag, a 20-bit word address, write data and four byte enables. Read results return later on a data bus qualified by a one-cycle valid flag.

Every access is a single-word burst. The controller opens the target row with a bank-activate command and waits the row-to-column delay. It then issues the read or write with auto precharge, so the row closes by itself. It waits out the row cycle and precharge recovery before it takes the next request. After reset it waits a power-up delay, precharges both banks, runs two refreshes and loads the mode register. A free-running timer asks for an auto-refresh at a fixed interval. That refresh wins over new host traffic as soon as the access in flight has recovered.

All command, address, mask and data pins are registered and change only on the rising clock edge. The memory samples them at the next edge. The clock-enable pin of the memory is tied high outside this block.

Top module: `sgram_ctrl`

## Requirements
- R1: After reset, only NOP (0111) is driven for at least T_POWERUP cycles. The first four non-NOP commands are then precharge with sdAddr[8]=1 (both banks), refresh, refresh and mode load, in that order. reqReady stays low until the mode load has been issued.
- R2: The mode load drives sdBs=0 and sdAddr = CAS_LAT<<4. That selects burst length 1 (bits 2:0 = 000) and sequential order (bit 3 = 0), with every other bit zero.
- R3: The host address splits as reqAddr[19] = bank, reqAddr[18:8] = row and reqAddr[7:0] = column. Activate drives the row on sdAddr and the bank on sdBs. Read and write drive the column on sdAddr[7:0] with sdAddr[8]=1 (auto precharge) and the same bank.
- R4: The pins {sdCsN,sdRasN,sdCasN,sdWeN} only ever carry these codes: activate 0011, read 0101, write 0100, precharge 0010, refresh 0001, mode load 0000, NOP 0111.
- R5: Read data is sampled from sdDqIn exactly CAS_LAT clock edges after the edge that samples the read command. rspData/rspValid present it for one cycle starting at that edge. There is exactly one rspValid per read and none for a write.
- R6: Write data, sdDqOe=1 and sdDqm = ~reqBe appear in the same cycle as the write command, so a byte whose enable is 0 is not written. sdDqOe is high in no other cycle.
- R7: A read or write reaches a bank that is open and comes at least T_RCD cycles after its activate. An activate reaches a closed bank and comes at least T_RC cycles after that bank's previous activate.
- R8: Auto-refresh repeats with a period of T_REFI cycles. Two consecutive refreshes are never more than T_REFI + T_RC + T_MRD + T_RCD + recovery + 4 cycles apart, where recovery = max(T_RC-T_RCD, T_WR+T_RP, CAS_LAT+T_RP).
- R9: While a refresh is due, no host request is accepted. The refresh is issued as soon as the access in flight has recovered, even with requests waiting.
- R10: reqReady is high only while the controller is idle. Each accepted request produces exactly one activate and one read or write.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge active |
| rstN | input | 1 | Active-low synchronous reset |
| reqValid | input | 1 | Host request present |
| reqReady | output | 1 | Controller accepts the request this cycle |
| reqWrite | input | 1 | 1 = write, 0 = read |
| reqAddr | input | 20 | Word address {bank, row, column} |
| reqWdata | input | 32 | Write data |
| reqBe | input | 4 | Byte enables, bit i covers data bits 8i+7:8i |
| rspValid | output | 1 | Read data valid, one cycle per read |
| rspData | output | 32 | Read data |
| sdCsN | output | 1 | Memory chip select, active low |
| sdRasN | output | 1 | Memory row strobe, active low |
| sdCasN | output | 1 | Memory column strobe, active low |
| sdWeN | output | 1 | Memory write enable, active low |
| sdBs | output | 1 | Memory bank select |
| sdAddr | output | 11 | Memory row / column / mode address |
| sdDqm | output | 4 | Per-byte data mask, high blocks the byte |
| sdDqOut | output | 32 | Data driven to memory |
| sdDqOe | output | 1 | Output enable for sdDqOut |
| sdDqIn | input | 32 | Data returned by memory |

## Verification
The bench builds the controller with CAS_LAT=1, the shortest latency. Here the read result is captured one edge after the read command, and any extra pipeline stage shows up as a timing mismatch. T_POWERUP=60 and T_REFI=150 keep the power-up wait short and make refresh fall due many times during back-to-back host traffic. This shows refresh priority against a host that never stops asking, and shows the interval bound on many refreshes. T_RC=11 against T_RCD=3 makes the row-cycle limit, not the precharge time, set the recovery between accesses.

// File: rtl/sgram_ctrl_pkg.sv
package sgram_ctrl_pkg;

  // {csN, rasN, casN, weN}
  typedef enum logic [3:0] {
    CMD_MRS = 4'b0000,
    CMD_REF = 4'b0001,
    CMD_PRE = 4'b0010,
    CMD_ACT = 4'b0011,
    CMD_WR  = 4'b0100,
    CMD_RD  = 4'b0101,
    CMD_NOP = 4'b0111
  } cmd_e;

  typedef enum logic [1:0] {
    ADR_ROW,
    ADR_COL,
    ADR_MODE,
    ADR_ALL
  } adrSel_e;

  typedef struct packed {
    cmd_e    cmd;
    adrSel_e adrSel;
    logic    latch;
  } strobe_t;

endpackage

// File: rtl/sgram_ctrl_reftmr.sv
module sgram_ctrl_reftmr #(
  parameter int T_REFI = 3120
) (
  input  logic clk,
  input  logic rstN,
  input  logic enable,
  input  logic refTaken,
  output logic refDue
);
  localparam int CW = $clog2(T_REFI + 1);

  logic [CW-1:0] cntQ;

  always_ff @(posedge clk) begin
    if (!rstN) begin
      cntQ   <= CW'(T_REFI - 1);
      refDue <= 1'b0;
    end else begin
      if (!enable) begin
        cntQ <= CW'(T_REFI - 1);
      end else if (cntQ == '0) begin
        cntQ <= CW'(T_REFI - 1);
      end else begin
        cntQ <= cntQ - 1'b1;
      end
      if (enable && cntQ == '0) begin
        refDue <= 1'b1;
      end else if (refTaken) begin
        refDue <= 1'b0;
      end
    end
  end
endmodule

// File: rtl/sgram_ctrl_fsm.sv
module sgram_ctrl_fsm
  import sgram_ctrl_pkg::*;
#(
  parameter int CAS_LAT   = 3,
  parameter int T_POWERUP = 40000,
  parameter int T_RC      = 11,
  parameter int T_RCD     = 3,
  parameter int T_RP      = 3,
  parameter int T_MRD     = 2,
  parameter int T_WR      = 2
) (
  input  logic    clk,
  input  logic    rstN,
  input  logic    reqValid,
  input  logic    reqIsWr,
  input  logic    refDue,
  output logic    reqReady,
  output logic    initDone,
  output logic    refTaken,
  output strobe_t strobe
);
  localparam int REC_A   = T_RC - T_RCD;
  localparam int REC_B   = T_WR + T_RP;
  localparam int REC_C   = CAS_LAT + T_RP;
  localparam int REC_AB  = (REC_A > REC_B) ? REC_A : REC_B;
  localparam int T_RWREC = (REC_AB > REC_C) ? REC_AB : REC_C;
  localparam int CW      = $clog2(T_POWERUP + T_RC + T_RWREC + 8);

  typedef enum logic [3:0] {
    S_PWR, S_PALL, S_IREF1, S_IREF2, S_MRS, S_WAIT, S_IDLE, S_REF, S_ACT, S_RW
  } st_e;

  st_e           state, stNxt, retQ, retNxt;
  logic [CW-1:0] cntQ, cntNxt;
  logic          initQ;

  always_comb begin
    stNxt  = state;
    retNxt = retQ;
    cntNxt = cntQ;
    strobe = '{cmd: CMD_NOP, adrSel: ADR_ROW, latch: 1'b0};
    case (state)
      S_PWR: begin
        if (cntQ == '0) stNxt = S_PALL;
        else            cntNxt = cntQ - 1'b1;
      end
      S_PALL: begin
        strobe.cmd    = CMD_PRE;
        strobe.adrSel = ADR_ALL;
        cntNxt = CW'(T_RP - 2);
        retNxt = S_IREF1;
        stNxt  = S_WAIT;
      end
      S_IREF1, S_IREF2: begin
        strobe.cmd = CMD_REF;
        cntNxt = CW'(T_RC - 2);
        retNxt = (state == S_IREF1) ? S_IREF2 : S_MRS;
        stNxt  = S_WAIT;
      end
      S_MRS: begin
        strobe.cmd    = CMD_MRS;
        strobe.adrSel = ADR_MODE;
        cntNxt = CW'(T_MRD - 2);
        retNxt = S_IDLE;
        stNxt  = S_WAIT;
      end
      S_WAIT: begin
        if (cntQ == '0) stNxt = retQ;
        else            cntNxt = cntQ - 1'b1;
      end
      S_IDLE: begin
        if (refDue) begin
          stNxt = S_REF;
        end else if (reqValid) begin
          strobe.latch = 1'b1;
          stNxt = S_ACT;
        end
      end
      S_REF: begin
        strobe.cmd = CMD_REF;
        cntNxt = CW'(T_RC - 2);
        retNxt = S_IDLE;
        stNxt  = S_WAIT;
      end
      S_ACT: begin
        strobe.cmd    = CMD_ACT;
        strobe.adrSel = ADR_ROW;
        cntNxt = CW'(T_RCD - 2);
        retNxt = S_RW;
        stNxt  = S_WAIT;
      end
      S_RW: begin
        strobe.cmd    = reqIsWr ? CMD_WR : CMD_RD;
        strobe.adrSel = ADR_COL;
        cntNxt = CW'(T_RWREC - 2);
        retNxt = S_IDLE;
        stNxt  = S_WAIT;
      end
      default: stNxt = S_IDLE;
    endcase
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      state <= S_PWR;
      retQ  <= S_IDLE;
      cntQ  <= CW'(T_POWERUP - 1);
      initQ <= 1'b0;
    end else begin
      state <= stNxt;
      retQ  <= retNxt;
      cntQ  <= cntNxt;
      if (state == S_MRS) initQ <= 1'b1;
    end
  end

  assign reqReady = (state == S_IDLE) && !refDue;
  assign refTaken = (state == S_REF);
  assign initDone = initQ;
endmodule

// File: rtl/sgram_ctrl_dp.sv
module sgram_ctrl_dp
  import sgram_ctrl_pkg::*;
#(
  parameter int BANK_W  = 1,
  parameter int ROW_W   = 11,
  parameter int COL_W   = 8,
  parameter int DATA_W  = 32,
  parameter int CAS_LAT = 3,
  localparam int ADDR_W = BANK_W + ROW_W + COL_W,
  localparam int BE_W   = DATA_W / 8
) (
  input  logic              clk,
  input  logic              rstN,
  input  strobe_t           strobe,
  input  logic              reqWrite,
  input  logic [ADDR_W-1:0] reqAddr,
  input  logic [DATA_W-1:0] reqWdata,
  input  logic [BE_W-1:0]   reqBe,
  output logic              reqIsWr,
  output logic              rspValid,
  output logic [DATA_W-1:0] rspData,
  output logic              sdCsN,
  output logic              sdRasN,
  output logic              sdCasN,
  output logic              sdWeN,
  output logic [BANK_W-1:0] sdBs,
  output logic [ROW_W-1:0]  sdAddr,
  output logic [BE_W-1:0]   sdDqm,
  output logic [DATA_W-1:0] sdDqOut,
  output logic              sdDqOe,
  input  logic [DATA_W-1:0] sdDqIn
);
  localparam int AP_BIT = COL_W;
  localparam logic [ROW_W-1:0] AP_MASK   = ROW_W'(1) << AP_BIT;
  localparam logic [ROW_W-1:0] MODE_WORD = ROW_W'(CAS_LAT) << 4;

  logic [BANK_W-1:0] bankQ;
  logic [ROW_W-1:0]  rowQ;
  logic [COL_W-1:0]  colQ;
  logic [DATA_W-1:0] wdataQ;
  logic [BE_W-1:0]   beQ;
  logic              wrQ;
  logic [ROW_W-1:0]  adrNxt;
  logic [BANK_W-1:0] bsNxt;
  logic              pinIsRd;
  logic [CAS_LAT-1:0] rdPipe;

  always_ff @(posedge clk) begin
    if (!rstN) begin
      bankQ  <= '0;
      rowQ   <= '0;
      colQ   <= '0;
      wdataQ <= '0;
      beQ    <= '0;
      wrQ    <= 1'b0;
    end else if (strobe.latch) begin
      {bankQ, rowQ, colQ} <= reqAddr;
      wdataQ <= reqWdata;
      beQ    <= reqBe;
      wrQ    <= reqWrite;
    end
  end

  assign reqIsWr = wrQ;

  always_comb begin
    bsNxt = bankQ;
    case (strobe.adrSel)
      ADR_ROW:  adrNxt = rowQ;
      ADR_COL:  adrNxt = ROW_W'(colQ) | AP_MASK;
      ADR_MODE: begin adrNxt = MODE_WORD; bsNxt = '0; end
      default:  begin adrNxt = AP_MASK;   bsNxt = '0; end
    endcase
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      {sdCsN, sdRasN, sdCasN, sdWeN} <= CMD_NOP;
      sdBs    <= '0;
      sdAddr  <= '0;
      sdDqm   <= '0;
      sdDqOut <= '0;
      sdDqOe  <= 1'b0;
    end else begin
      {sdCsN, sdRasN, sdCasN, sdWeN} <= strobe.cmd;
      sdBs   <= bsNxt;
      sdAddr <= adrNxt;
      if (strobe.cmd == CMD_WR) begin
        sdDqOut <= wdataQ;
        sdDqm   <= ~beQ;
        sdDqOe  <= 1'b1;
      end else begin
        sdDqm  <= '0;
        sdDqOe <= 1'b0;
      end
    end
  end

  assign pinIsRd = ({sdCsN, sdRasN, sdCasN, sdWeN} == CMD_RD);

  generate
    if (CAS_LAT == 1) begin : g_cl1
      always_ff @(posedge clk) begin
        if (!rstN) rdPipe <= '0;
        else       rdPipe <= pinIsRd;
      end
    end else begin : g_cln
      always_ff @(posedge clk) begin
        if (!rstN) rdPipe <= '0;
        else       rdPipe <= {rdPipe[CAS_LAT-2:0], pinIsRd};
      end
    end
  endgenerate

  always_ff @(posedge clk) begin
    if (!rstN) begin
      rspValid <= 1'b0;
      rspData  <= '0;
    end else begin
      rspValid <= rdPipe[CAS_LAT-1];
      if (rdPipe[CAS_LAT-1]) rspData <= sdDqIn;
    end
  end
endmodule

// File: rtl/sgram_ctrl.sv
module sgram_ctrl
  import sgram_ctrl_pkg::*;
#(
  parameter int BANK_W    = 1,
  parameter int ROW_W     = 11,
  parameter int COL_W     = 8,
  parameter int DATA_W    = 32,
  parameter int CAS_LAT   = 3,
  parameter int T_POWERUP = 40000,
  parameter int T_REFI    = 3120,
  parameter int T_RC      = 11,
  parameter int T_RCD     = 3,
  parameter int T_RP      = 3,
  parameter int T_MRD     = 2,
  parameter int T_WR      = 2,
  localparam int ADDR_W   = BANK_W + ROW_W + COL_W,
  localparam int BE_W     = DATA_W / 8
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              reqValid,
  output logic              reqReady,
  input  logic              reqWrite,
  input  logic [ADDR_W-1:0] reqAddr,
  input  logic [DATA_W-1:0] reqWdata,
  input  logic [BE_W-1:0]   reqBe,
  output logic              rspValid,
  output logic [DATA_W-1:0] rspData,
  output logic              sdCsN,
  output logic              sdRasN,
  output logic              sdCasN,
  output logic              sdWeN,
  output logic [BANK_W-1:0] sdBs,
  output logic [ROW_W-1:0]  sdAddr,
  output logic [BE_W-1:0]   sdDqm,
  output logic [DATA_W-1:0] sdDqOut,
  output logic              sdDqOe,
  input  logic [DATA_W-1:0] sdDqIn
);
  strobe_t strobe;
  logic    reqIsWr, refDue, refTaken, initDone;

  sgram_ctrl_fsm #(
    .CAS_LAT(CAS_LAT), .T_POWERUP(T_POWERUP), .T_RC(T_RC), .T_RCD(T_RCD),
    .T_RP(T_RP), .T_MRD(T_MRD), .T_WR(T_WR)
  ) u_fsm (
    .clk(clk), .rstN(rstN), .reqValid(reqValid), .reqIsWr(reqIsWr),
    .refDue(refDue), .reqReady(reqReady), .initDone(initDone),
    .refTaken(refTaken), .strobe(strobe)
  );

  sgram_ctrl_reftmr #(.T_REFI(T_REFI)) u_ref (
    .clk(clk), .rstN(rstN), .enable(initDone), .refTaken(refTaken), .refDue(refDue)
  );

  sgram_ctrl_dp #(
    .BANK_W(BANK_W), .ROW_W(ROW_W), .COL_W(COL_W), .DATA_W(DATA_W), .CAS_LAT(CAS_LAT)
  ) u_dp (
    .clk(clk), .rstN(rstN), .strobe(strobe), .reqWrite(reqWrite), .reqAddr(reqAddr),
    .reqWdata(reqWdata), .reqBe(reqBe), .reqIsWr(reqIsWr), .rspValid(rspValid),
    .rspData(rspData), .sdCsN(sdCsN), .sdRasN(sdRasN), .sdCasN(sdCasN), .sdWeN(sdWeN),
    .sdBs(sdBs), .sdAddr(sdAddr), .sdDqm(sdDqm), .sdDqOut(sdDqOut), .sdDqOe(sdDqOe),
    .sdDqIn(sdDqIn)
  );
endmodule

// File: rtl/sgram_ctrl_chk.sv
module sgram_ctrl_chk
  import sgram_ctrl_pkg::*;
#(
  parameter int ROW_W   = 11,
  parameter int COL_W   = 8,
  parameter int CAS_LAT = 3,
  parameter int T_RCD   = 3
) (
  input logic             clk,
  input logic             rstN,
  input logic             reqValid,
  input logic             reqReady,
  input logic             rspValid,
  input logic             sdCsN,
  input logic             sdRasN,
  input logic             sdCasN,
  input logic             sdWeN,
  input logic [ROW_W-1:0] sdAddr,
  input logic             sdDqOe,
  input logic             refDue
);
  logic [3:0] pinCmd;
  logic [7:0] sinceAct;
  logic       mrsSeen;
  logic       isRw;

  assign pinCmd = {sdCsN, sdRasN, sdCasN, sdWeN};
  assign isRw   = (pinCmd == CMD_RD) || (pinCmd == CMD_WR);

  always_ff @(posedge clk) begin
    if (!rstN) begin
      sinceAct <= '0;
      mrsSeen  <= 1'b0;
    end else begin
      if (pinCmd == CMD_ACT)       sinceAct <= 8'd1;
      else if (sinceAct != 8'hFF && sinceAct != 8'd0) sinceAct <= sinceAct + 8'd1;
      if (pinCmd == CMD_MRS) mrsSeen <= 1'b1;
    end
  end

  a_r1_ready_after_mode: assert property (@(posedge clk) disable iff (!rstN)
    reqReady |-> mrsSeen);

  a_r3_auto_precharge: assert property (@(posedge clk) disable iff (!rstN)
    isRw |-> sdAddr[COL_W]);

  a_r4_legal_cmd: assert property (@(posedge clk) disable iff (!rstN)
    (pinCmd == CMD_MRS) || (pinCmd == CMD_REF) || (pinCmd == CMD_PRE) ||
    (pinCmd == CMD_ACT) || (pinCmd == CMD_WR) || (pinCmd == CMD_RD) ||
    (pinCmd == CMD_NOP));

  a_r5_rsp_after_read: assert property (@(posedge clk) disable iff (!rstN)
    rspValid |-> $past(pinCmd == CMD_RD, CAS_LAT + 1));

  a_r6_oe_on_write: assert property (@(posedge clk) disable iff (!rstN)
    sdDqOe |-> (pinCmd == CMD_WR));

  a_r7_act_to_rw: assert property (@(posedge clk) disable iff (!rstN)
    isRw |-> (sinceAct >= 8'(T_RCD)));

  a_r9_no_accept_due: assert property (@(posedge clk) disable iff (!rstN)
    refDue |-> !(reqValid && reqReady));
endmodule

bind sgram_ctrl sgram_ctrl_chk #(
  .ROW_W(ROW_W), .COL_W(COL_W), .CAS_LAT(CAS_LAT), .T_RCD(T_RCD)
) u_chk (
  .clk(clk), .rstN(rstN), .reqValid(reqValid), .reqReady(reqReady),
  .rspValid(rspValid), .sdCsN(sdCsN), .sdRasN(sdRasN), .sdCasN(sdCasN),
  .sdWeN(sdWeN), .sdAddr(sdAddr), .sdDqOe(sdDqOe), .refDue(refDue)
);

// File: tb/sim_sgram_ctrl.sv
module sim_sgram_ctrl;
  localparam int CL    = 1;
  localparam int TPU   = 60;
  localparam int TREFI = 150;
  localparam int TRC   = 11;
  localparam int TRCD  = 3;
  localparam int TRP   = 3;
  localparam int TMRD  = 2;
  localparam int TWR   = 2;
  localparam int RA    = TRC - TRCD;
  localparam int RB    = TWR + TRP;
  localparam int RC    = CL + TRP;
  localparam int RAB   = (RA > RB) ? RA : RB;
  localparam int TREC  = (RAB > RC) ? RAB : RC;
  localparam int SLACK = TRC + TMRD + TRCD + TREC + 4;

  localparam logic [3:0] C_MRS = 4'b0000, C_REF = 4'b0001, C_PRE = 4'b0010,
                         C_ACT = 4'b0011, C_WR = 4'b0100, C_RD = 4'b0101,
                         C_NOP = 4'b0111;

  logic        clk = 0, rstN = 0;
  logic        reqValid = 0, reqReady, reqWrite = 0;
  logic [19:0] reqAddr = '0;
  logic [31:0] reqWdata = '0;
  logic [3:0]  reqBe = '0;
  logic        rspValid;
  logic [31:0] rspData;
  logic        sdCsN, sdRasN, sdCasN, sdWeN, sdBs, sdDqOe;
  logic [10:0] sdAddr;
  logic [3:0]  sdDqm;
  logic [31:0] sdDqOut;
  logic [31:0] sdDqIn = '0;

  sgram_ctrl #(
    .CAS_LAT(CL), .T_POWERUP(TPU), .T_REFI(TREFI), .T_RC(TRC), .T_RCD(TRCD),
    .T_RP(TRP), .T_MRD(TMRD), .T_WR(TWR)
  ) u0 (
    .clk(clk), .rstN(rstN), .reqValid(reqValid), .reqReady(reqReady),
    .reqWrite(reqWrite), .reqAddr(reqAddr), .reqWdata(reqWdata), .reqBe(reqBe),
    .rspValid(rspValid), .rspData(rspData), .sdCsN(sdCsN), .sdRasN(sdRasN),
    .sdCasN(sdCasN), .sdWeN(sdWeN), .sdBs(sdBs), .sdAddr(sdAddr), .sdDqm(sdDqm),
    .sdDqOut(sdDqOut), .sdDqOe(sdDqOe), .sdDqIn(sdDqIn)
  );

  always #2 clk = ~clk;

  int checks = 0, errors = 0;

  task automatic chk(bit ok, string req, logic [31:0] act, logic [31:0] exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  // ---------------- memory model and command monitor ----------------
  int          cyc = 0, relCyc = 0, lastRef = -1, lastRdCyc = 0, initIdx = 0;
  int          nAct = 0, nRd = 0, nRef = 0;
  int          actCyc [2];
  logic        bankOpen [2];
  logic [10:0] openRow [2];
  logic [31:0] dram [int];
  logic [31:0] pend [4];
  logic [3:0]  seq [4];
  logic [3:0]  mc;
  int          mkey;
  logic [31:0] mw;

  initial begin
    seq[0] = C_PRE; seq[1] = C_REF; seq[2] = C_REF; seq[3] = C_MRS;
    for (int i = 0; i < 2; i++) begin actCyc[i] = -1000; bankOpen[i] = 0; openRow[i] = '0; end
    for (int i = 0; i < 4; i++) pend[i] = '0;
  end

  always @(posedge clk) begin
    mc = {sdCsN, sdRasN, sdCasN, sdWeN};
    if (!rstN) begin
      relCyc = cyc + 1;
    end else begin
      if (mc != C_NOP && initIdx < 4) begin
        chk(mc == seq[initIdx], "R1 init order", 32'(mc), 32'(seq[initIdx]));
        if (initIdx == 0) chk(cyc - relCyc >= TPU, "R1 power-up wait", cyc - relCyc, TPU);
        initIdx++;
      end
      if (sdDqOe && mc != C_WR) chk(0, "R6 oe outside write", 32'(mc), 32'(C_WR));
      case (mc)
        C_NOP: ;
        C_ACT: begin
          chk(!bankOpen[sdBs], "R7 activate to closed bank", 32'(bankOpen[sdBs]), 0);
          chk(cyc - actCyc[sdBs] >= TRC, "R7 activate spacing", cyc - actCyc[sdBs], TRC);
          bankOpen[sdBs] = 1; openRow[sdBs] = sdAddr; actCyc[sdBs] = cyc; nAct++;
        end
        C_RD, C_WR: begin
          chk(bankOpen[sdBs] && (cyc - actCyc[sdBs] >= TRCD), "R7 column after activate",
              cyc - actCyc[sdBs], TRCD);
          chk(sdAddr[8], "R3 auto precharge bit", 32'(sdAddr), 32'h100);
          mkey = int'({sdBs, openRow[sdBs], sdAddr[7:0]});
          if (mc == C_WR) begin
            chk(sdDqOe, "R6 data with write", 32'(sdDqOe), 1);
            mw = dram.exists(mkey) ? dram[mkey] : 32'h0;
            for (int b = 0; b < 4; b++) if (!sdDqm[b]) mw[8*b +: 8] = sdDqOut[8*b +: 8];
            dram[mkey] = mw;
          end else begin
            pend[CL-1] = dram.exists(mkey) ? dram[mkey] : 32'h0;
            lastRdCyc = cyc; nRd++;
          end
          bankOpen[sdBs] = 0;
        end
        C_REF: begin
          chk(!bankOpen[0] && !bankOpen[1], "R9 refresh with banks closed", 0, 0);
          if (lastRef >= 0)
            chk(cyc - lastRef <= TREFI + SLACK, "R8 R9 refresh interval",
                cyc - lastRef, TREFI + SLACK);
          lastRef = cyc; nRef++;
        end
        C_MRS: chk(sdAddr == 11'(CL << 4) && !sdBs, "R2 mode word", 32'(sdAddr), CL << 4);
        C_PRE: chk(sdAddr[8], "R1 precharge all", 32'(sdAddr), 32'h100);
        default: chk(0, "R4 legal command", 32'(mc), 32'(C_NOP));
      endcase
    end
    sdDqIn <= pend[0];
    for (int i = 0; i < 3; i++) pend[i] = pend[i+1];
    pend[3] = '0;
    cyc = cyc + 1;
  end

  // ---------------- host side ----------------
  logic [31:0] expMem [int];
  logic [19:0] pool [16];
  int          nAcc = 0, nReads = 0;

  function automatic logic [31:0] merge(logic [31:0] o, logic [31:0] d, logic [3:0] be);
    logic [31:0] r = o;
    for (int b = 0; b < 4; b++) if (be[b]) r[8*b +: 8] = d[8*b +: 8];
    return r;
  endfunction

  task automatic hostReq(bit wr, logic [19:0] a, logic [31:0] d, logic [3:0] be);
    @(negedge clk);
    reqValid = 1; reqWrite = wr; reqAddr = a; reqWdata = d; reqBe = be;
    while (!reqReady) @(negedge clk);
    @(negedge clk);
    reqValid = 0; nAcc++;
  endtask

  task automatic doWrite(logic [19:0] a, logic [31:0] d, logic [3:0] be);
    logic [31:0] o = expMem.exists(int'(a)) ? expMem[int'(a)] : 32'h0;
    hostReq(1, a, d, be);
    chk(!reqReady, "R10 busy after accept", 32'(reqReady), 0);
    expMem[int'(a)] = merge(o, d, be);
  endtask

  task automatic doRead(logic [19:0] a, string tag);
    logic [31:0] e = expMem.exists(int'(a)) ? expMem[int'(a)] : 32'h0;
    int n = 0;
    hostReq(0, a, 32'h0, 4'h0);
    nReads++;
    while (!rspValid && n < 40) begin @(negedge clk); n++; end
    chk(rspValid, {tag, " response arrives"}, 32'(rspValid), 1);
    chk(rspData == e, {tag, " read data"}, rspData, e);
    chk(cyc - lastRdCyc == CL + 1, "R5 capture latency", cyc - lastRdCyc, CL + 1);
    @(negedge clk);
    chk(!rspValid, "R5 single valid pulse", 32'(rspValid), 0);
  endtask

  task automatic runMain();
    int w, r0;
    void'($urandom(32'd4242));
    repeat (3) @(negedge clk);
    chk(!reqReady && !rspValid && !sdDqOe && {sdCsN, sdRasN, sdCasN, sdWeN} == C_NOP,
        "R1 reset state", {sdCsN, sdRasN, sdCasN, sdWeN}, 32'(C_NOP));
    rstN = 1;
    @(negedge clk);
    chk(!reqReady, "R1 not ready during power-up", 32'(reqReady), 0);
    w = 0;
    while (!reqReady && w < 1000) begin @(negedge clk); w++; end
    chk(initIdx == 4, "R1 init complete before ready", initIdx, 4);

    pool[0] = 20'h00000;               pool[1] = 20'hFFFFF;
    pool[2] = {1'b0, 11'h7FF, 8'h00};  pool[3] = {1'b1, 11'h000, 8'hFF};
    pool[4] = {1'b0, 11'h005, 8'h10};  pool[5] = {1'b0, 11'h006, 8'h10};
    pool[6] = {1'b1, 11'h005, 8'h10};
    for (int i = 7; i < 16; i++) pool[i] = 20'($urandom);

    for (int i = 0; i < 16; i++) doWrite(pool[i], $urandom, 4'hF);
    // R3: same column, different rows and banks must stay distinct
    doRead(pool[4], "R3 row split");
    doRead(pool[5], "R3 row split");
    doRead(pool[6], "R3 bank split");
    doRead(pool[1], "R3 top address");
    // R6: no byte enabled leaves word unchanged; partial mask
    doWrite(pool[0], 32'hDEADBEEF, 4'h0);
    doRead(pool[0], "R6 all masked");
    doWrite(pool[0], 32'hA1B2C3D4, 4'h5);
    doRead(pool[0], "R6 partial mask");
    doWrite(pool[3], 32'h11223344, 4'h8);
    doRead(pool[3], "R6 top byte");

    for (int k = 0; k < 300; k++) begin
      r0 = int'($urandom_range(15, 0));
      if ($urandom_range(1, 0) == 1) doWrite(pool[r0], $urandom, 4'($urandom));
      else                           doRead(pool[r0], "R5 random read");
    end

    w = nRef;
    repeat (3 * TREFI) @(negedge clk);
    chk(nRef - w >= 2, "R8 refresh while idle", nRef - w, 2);
    chk(nAct == nAcc, "R10 one activate per request", nAct, nAcc);
    chk(nRd == nReads, "R10 one read command per read", nRd, nReads);
  endtask

  initial begin
    fork
      runMain();
      begin
        repeat (150000) @(posedge clk);
        errors++;
        $display("FAIL watchdog expired actual=%0d expected=%0d", cyc, 0);
      end
    join_any
    disable fork;
    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule